// File: doc/BRIEF.md
# Video Sync Output Formatter

This block sits at the output edge of a video receiver and conditions its timing signals before they leave the chip. It rebuilds the horizontal sync pulse rather than forwarding the incoming one. A rising edge on the internal horizontal reference starts a pulse, and the pulse ends after a programmable number of pixel clocks. The vertical sync, display enable, field and composite-sync outputs are passed through. Each output has its own polarity bit.

The composite-sync pin can carry one of four sources: the sliced sync, the raw horizontal sync, the regenerated sync from the sync filter, or the horizontal sync that feeds the PLL. The sync slicer, the sync filter and clock generation are outside this block, so all four sources arrive as plain inputs. Two registers set the pulse width and the polarity/select fields. Software loads them through a single-cycle write port. Every output leaves through a flop, so the outputs lag their inputs by one pixel clock and do not glitch when a setting changes.

Top module: `sync_fmt_top`

## Requirements
- R1: Reset state. While reset is asserted, every output is 0. After reset, the width register holds DUR_RST (default 32) and the control register holds 0xFE.
- R2: Pulse start and width. The horizontal reference is sampled high at edge T after being low at the edge before. The hsync pulse is then active at hs_o after edges T+1 through T+W, where W is the width register, and inactive after edge T+W+1.
- R3: A width value of 0 produces no active level on hs_o. A reference edge that loads 0 ends any pulse in progress.
- R4: A reference edge that arrives during a pulse reloads the count, which extends the pulse. Edges k cycles apart with width W give k+W active cycles.
- R5: Writing the width register during a pulse leaves that pulse's length unchanged. The new value applies from the next reference edge.
- R6: Control bit 7 sets hsync polarity. With 1 the pulse is high and idle is low. With 0 the levels are inverted.
- R7: Control bits 6 and 5 set the polarity of vs_o and de_o. With 1 the output equals the input one cycle later. With 0 it is the inverted input.
- R8: Control bit 4 sets the field output sense, where field_i is 1 for an odd field. With 1, an odd field drives field_o low and an even field drives it high. With 0, the sense is reversed.
- R9: Control bits 2:1 select the composite-sync source: 00 sliced sync, 01 raw hsync, 10 regenerated sync, 11 PLL hsync. Control bit 3 sets its polarity (1 means non-inverted). The output lags by one cycle.
- R10: Control bit 0 appears at clk_inv_o two edges after the write edge: one edge for the register and one for the output flop. It resets to 0.
- R11: A write with wr_addr 0 loads the width register. A write with wr_addr 1 loads the control register. The new value is held from the write edge, and registers keep their value when no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the width register, 1 the control register |
| wr_data | input | 8 | Write data |
| href_i | input | 1 | Internal horizontal reference; a rising edge starts a pulse |
| vs_i | input | 1 | Internal vertical sync, active high |
| de_i | input | 1 | Internal display enable, active high |
| field_i | input | 1 | Internal field flag, 1 means odd field |
| sync_slice_i | input | 1 | Sliced sync source |
| hsync_raw_i | input | 1 | Raw horizontal sync source |
| sync_regen_i | input | 1 | Regenerated sync source |
| hsync_pll_i | input | 1 | Horizontal sync sent to the PLL |
| hs_o | output | 1 | Regenerated horizontal sync |
| vs_o | output | 1 | Formatted vertical sync |
| de_o | output | 1 | Formatted display enable |
| field_o | output | 1 | Formatted field flag |
| csync_o | output | 1 | Selected composite-sync output |
| clk_inv_o | output | 1 | Output clock invert setting |

## Verification
The bench builds the block with the default parameters: an 8-bit width register that resets to 32. This makes the whole width range reachable, including the zero-width case and the 255-cycle maximum.

Directed runs count hs_o active cycles in the following cases:
- after a single edge;
- after a retrigger;
- across a mid-pulse width write;
- under inverted polarity.

A reference model fed by the same stimulus scores every output on every cycle. It does so while random control words cycle through all four source codes and both levels of every polarity bit.

// File: rtl/sync_fmt_pkg.sv
package sync_fmt_pkg;

   localparam int REG_W = 8;

   typedef enum logic [1:0] {
      CS_SLICE = 2'b00,
      CS_HRAW  = 2'b01,
      CS_REGEN = 2'b10,
      CS_PLL   = 2'b11
   } cs_src_e;

   typedef struct packed {
      logic    hs_pol;
      logic    vs_pol;
      logic    de_pol;
      logic    fld_pol;
      logic    cs_pol;
      cs_src_e cs_sel;
      logic    clk_inv;
   } ctrl_t;

   localparam logic [REG_W-1:0] CTRL_RST = 8'hFE;

   localparam int LN_HS  = 0;
   localparam int LN_VS  = 1;
   localparam int LN_DE  = 2;
   localparam int LN_FLD = 3;
   localparam int LN_CS  = 4;
   localparam int LN_CI  = 5;
   localparam int LANES  = 6;

endpackage

// File: rtl/sync_fmt_regs.sv
module sync_fmt_regs
   import sync_fmt_pkg::*;
#(
   parameter int DUR_W   = 8,
   parameter int DUR_RST = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [REG_W-1:0] wr_data,
   output logic [DUR_W-1:0] dur_o,
   output ctrl_t            ctrl_o
);

   localparam logic [DUR_W-1:0] DUR_INIT = DUR_W'(DUR_RST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dur_o  <= DUR_INIT;
         ctrl_o <= ctrl_t'(CTRL_RST);
      end else if (wr_en) begin
         if (wr_addr) ctrl_o <= ctrl_t'(wr_data);
         else         dur_o  <= wr_data[DUR_W-1:0];
      end
   end

   assert_dur_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr) |=> dur_o == $past(wr_data[DUR_W-1:0]));

   assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_o));

endmodule

// File: rtl/sync_fmt_hpulse.sv
module sync_fmt_hpulse #(
   parameter int DUR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             href_i,
   input  logic [DUR_W-1:0] dur_i,
   output logic             pulse_o
);

   localparam logic [DUR_W-1:0] ONE  = DUR_W'(1);
   localparam logic [DUR_W-1:0] ZERO = '0;

   logic             href_q;
   logic             lead;
   logic [DUR_W-1:0] cnt;

   assign lead    = href_i && !href_q;
   assign pulse_o = (cnt != ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         href_q <= 1'b0;
         cnt    <= ZERO;
      end else begin
         href_q <= href_i;
         if (lead)              cnt <= dur_i;
         else if (cnt != ZERO)  cnt <= cnt - ONE;
      end
   end

   assert_zero_dur_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lead && dur_i == ZERO) |=> !pulse_o);

   assert_retrig_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lead |=> cnt == $past(dur_i));

   assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lead && cnt != ZERO) |=> cnt == $past(cnt) - ONE);

   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!lead && cnt == ZERO) |=> !pulse_o);

endmodule

// File: rtl/sync_fmt_polout.sv
module sync_fmt_polout #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lane_i,
   input  logic [N-1:0] pol_i,
   output logic [N-1:0] lane_o
);

   for (genvar g = 0; g < N; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) lane_o[g] <= 1'b0;
         else        lane_o[g] <= pol_i[g] ? lane_i[g] : !lane_i[g];
      end
   end

endmodule

// File: rtl/sync_fmt_top.sv
module sync_fmt_top
   import sync_fmt_pkg::*;
#(
   parameter int DUR_W   = 8,
   parameter int DUR_RST = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_addr,
   input  logic [7:0] wr_data,
   input  logic       href_i,
   input  logic       vs_i,
   input  logic       de_i,
   input  logic       field_i,
   input  logic       sync_slice_i,
   input  logic       hsync_raw_i,
   input  logic       sync_regen_i,
   input  logic       hsync_pll_i,
   output logic       hs_o,
   output logic       vs_o,
   output logic       de_o,
   output logic       field_o,
   output logic       csync_o,
   output logic       clk_inv_o
);

   if (DUR_W < 1 || DUR_W > REG_W) begin : g_bad_width
      $error("sync_fmt_top: DUR_W must lie in 1..REG_W");
   end
   if (DUR_RST < 0 || DUR_RST >= (1 << DUR_W)) begin : g_bad_rst
      $error("sync_fmt_top: DUR_RST does not fit in DUR_W bits");
   end

   logic [DUR_W-1:0] dur;
   ctrl_t            ctrl;
   logic             pulse;
   logic             cs_mux;
   logic [LANES-1:0] lane_in;
   logic [LANES-1:0] lane_pol;
   logic [LANES-1:0] lane_out;

   sync_fmt_regs #(.DUR_W(DUR_W), .DUR_RST(DUR_RST)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .dur_o   (dur),
      .ctrl_o  (ctrl)
   );

   sync_fmt_hpulse #(.DUR_W(DUR_W)) hpulse_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .href_i  (href_i),
      .dur_i   (dur),
      .pulse_o (pulse)
   );

   always_comb begin
      unique case (ctrl.cs_sel)
         CS_SLICE: cs_mux = sync_slice_i;
         CS_HRAW:  cs_mux = hsync_raw_i;
         CS_REGEN: cs_mux = sync_regen_i;
         default:  cs_mux = hsync_pll_i;
      endcase
   end

   always_comb begin
      lane_in          = '0;
      lane_pol         = '0;
      lane_in[LN_HS]   = pulse;
      lane_pol[LN_HS]  = ctrl.hs_pol;
      lane_in[LN_VS]   = vs_i;
      lane_pol[LN_VS]  = ctrl.vs_pol;
      lane_in[LN_DE]   = de_i;
      lane_pol[LN_DE]  = ctrl.de_pol;
      lane_in[LN_FLD]  = field_i;
      lane_pol[LN_FLD] = !ctrl.fld_pol;
      lane_in[LN_CS]   = cs_mux;
      lane_pol[LN_CS]  = ctrl.cs_pol;
      lane_in[LN_CI]   = ctrl.clk_inv;
      lane_pol[LN_CI]  = 1'b1;
   end

   sync_fmt_polout #(.N(LANES)) polout_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lane_i (lane_in),
      .pol_i  (lane_pol),
      .lane_o (lane_out)
   );

   assign hs_o      = lane_out[LN_HS];
   assign vs_o      = lane_out[LN_VS];
   assign de_o      = lane_out[LN_DE];
   assign field_o   = lane_out[LN_FLD];
   assign csync_o   = lane_out[LN_CS];
   assign clk_inv_o = lane_out[LN_CI];

   assert_vs_pol_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> vs_o == ($past(vs_i) ~^ $past(ctrl.vs_pol)));

   assert_field_sense_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctrl.fld_pol) && $past(field_i)) |-> !field_o);

   assert_cs_pll_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.cs_sel == CS_PLL) |=> csync_o == ($past(hsync_pll_i) ~^ $past(ctrl.cs_pol)));

   assert_clkinv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr) |=> ##1 clk_inv_o == $past(wr_data[0], 2));

   assert_hs_pol_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(pulse)) |-> hs_o == !$past(ctrl.hs_pol));

endmodule

// File: tb/sync_fmt_tb_top.sv
module sync_fmt_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       href_i = 1'b0;
   logic       vs_i = 1'b0, de_i = 1'b0, field_i = 1'b0;
   logic       sync_slice_i = 1'b0, hsync_raw_i = 1'b0;
   logic       sync_regen_i = 1'b0, hsync_pll_i = 1'b0;
   logic       hs_o, vs_o, de_o, field_o, csync_o, clk_inv_o;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sync_fmt_top #(.DUR_W(8), .DUR_RST(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .href_i(href_i), .vs_i(vs_i), .de_i(de_i), .field_i(field_i),
      .sync_slice_i(sync_slice_i), .hsync_raw_i(hsync_raw_i),
      .sync_regen_i(sync_regen_i), .hsync_pll_i(hsync_pll_i),
      .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o), .field_o(field_o),
      .csync_o(csync_o), .clk_inv_o(clk_inv_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference model: registers per R1/R11, pulse per R2-R5, lanes per R6-R10.
   logic [5:0] exp_q[$];
   logic [7:0] m_dur, m_ctrl;
   logic [7:0] m_cnt;
   logic       m_hq;

   always @(posedge clk) begin
      logic [5:0] e;
      logic       src;
      if (!rst_n) begin
         m_dur = 8'd32; m_ctrl = 8'hFE; m_cnt = '0; m_hq = 1'b0;
      end else begin
         case (m_ctrl[2:1])
            2'b00:   src = sync_slice_i;
            2'b01:   src = hsync_raw_i;
            2'b10:   src = sync_regen_i;
            default: src = hsync_pll_i;
         endcase
         e[5] = ((m_cnt != 0) == m_ctrl[7]);
         e[4] = (vs_i == m_ctrl[6]);
         e[3] = (de_i == m_ctrl[5]);
         e[2] = (field_i != m_ctrl[4]);
         e[1] = (src == m_ctrl[3]);
         e[0] = m_ctrl[0];
         exp_q.push_back(e);
         if (href_i && !m_hq) m_cnt = m_dur;
         else if (m_cnt != 0) m_cnt = m_cnt - 8'd1;
         m_hq = href_i;
         if (wr_en) begin
            if (wr_addr) m_ctrl = wr_data;
            else         m_dur  = wr_data;
         end
      end
   end

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [5:0] e;
         e = exp_q.pop_front();
         check("R2/R6 hs_o",     hs_o,      e[5]);
         check("R7 vs_o",        vs_o,      e[4]);
         check("R7 de_o",        de_o,      e[3]);
         check("R8 field_o",     field_o,   e[2]);
         check("R9 csync_o",     csync_o,   e[1]);
         check("R10 clk_inv_o",  clk_inv_o, e[0]);
      end
   end

   task automatic wr(input logic a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_run(input int win, input int retrig_at, input int wr_at,
                            input logic [7:0] wr_val, input logic act, output int n);
      n = 0;
      href_i = 1'b1;
      for (int i = 1; i <= win; i++) begin
         @(negedge clk);
         if (hs_o === act) n++;
         href_i  = (i == retrig_at);
         wr_en   = (i == wr_at);
         wr_addr = 1'b0;
         wr_data = wr_val;
      end
      href_i = 1'b0;
      wr_en  = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check("R1 hs_o in reset", hs_o, 0);
      check("R1 vs_o in reset", vs_o, 0);
      check("R1 csync_o in reset", csync_o, 0);
      check("R1 clk_inv_o in reset", clk_inv_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      pulse_run(40, -1, -1, 8'd0, 1'b1, n);
      check("R1 default width 32", n, 32);

      wr(1'b0, 8'd5);
      pulse_run(12, -1, -1, 8'd0, 1'b1, n);
      check("R2 width 5", n, 5);

      wr(1'b0, 8'd255);
      pulse_run(262, -1, -1, 8'd0, 1'b1, n);
      check("R2 width 255", n, 255);

      wr(1'b0, 8'd0);
      pulse_run(10, -1, -1, 8'd0, 1'b1, n);
      check("R3 width 0", n, 0);

      wr(1'b0, 8'd10);
      pulse_run(20, 4, -1, 8'd0, 1'b1, n);
      check("R4 retrigger after 4", n, 14);

      wr(1'b0, 8'd8);
      pulse_run(14, -1, 2, 8'd3, 1'b1, n);
      check("R5 mid-pulse write keeps 8", n, 8);
      pulse_run(10, -1, -1, 8'd0, 1'b1, n);
      check("R5 new width 3 applies", n, 3);

      wr(1'b1, 8'h7E);
      wr(1'b0, 8'd6);
      pulse_run(12, -1, -1, 8'd0, 1'b0, n);
      check("R6 active-low width", n, 6);
      check("R6 idle level high", hs_o, 1);

      wr(1'b1, 8'hFF);
      @(negedge clk);
      check("R10 clk_inv_o set", clk_inv_o, 1);
      wr(1'b1, 8'hFE);
      @(negedge clk);
      check("R10 clk_inv_o clear", clk_inv_o, 0);

      vs_i = 1'b1; field_i = 1'b1;
      @(negedge clk);
      check("R7 vs active high", vs_o, 1);
      check("R8 odd field low with bit 1", field_o, 0);

      for (int k = 0; k < 2000; k++) begin
         if (k % 50 == 0) begin
            logic [7:0] r;
            r = 8'($urandom);
            wr(1'b1, {r[7:3], 2'(k / 50), r[0]});
            wr(1'b0, 8'($urandom_range(0, 12)));
         end
         vs_i = 1'($urandom); de_i = 1'($urandom); field_i = 1'($urandom);
         sync_slice_i = 1'($urandom); hsync_raw_i = 1'($urandom);
         sync_regen_i = 1'($urandom); hsync_pll_i = 1'($urandom);
         href_i = ($urandom_range(0, 15) == 0);
         @(negedge clk);
      end
      href_i = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule